// File: doc/BRIEF.md
# Dual-Mode Exposure Integration Timer

This block times pixel exposure for an image sensor core. A single 12-bit integration value is read in one of two ways, depending on the shutter mode input.

In global-shutter mode, a shutter-start strobe arms the timer. A prescaler divides the clock by 1, 4, 16 or 256 to form ticks. The timer counts these ticks up to the integration value and then emits a one-clock timeout pulse. The surrounding control uses that pulse to end the exposure.

In rolling-shutter mode, a frame-start strobe produces a read-pointer load sync, which loads the read pointer from its start value. Each row-clock pulse then advances the same counter. When the count reaches the integration value, the block issues a reset-pointer load sync once, together with the reset pointer's start value. This sets the row distance between the read pointer and the reset pointer. The exposure in rows is therefore the frame's line count minus that distance.

Top module: `shtr_integ_timer`

## Requirements
- R1: While reset is low, and in the cycle after a reset edge, `timeout`, `rd_sync` and `rst_sync` are 0 and both pointer outputs are 0.
- R2: Global mode (`shutter_mode`=0). The period G in clocks per tick is set by `gran_sel`: 0→1, 1→4, 2→16, 3→256. If `shutter_start` is sampled at clock edge E, then `timeout` is high for exactly the cycle that follows edge E+T·G, where T is the integration value.
- R3: In global mode, an `int_limit` below 10 is treated as 10.
- R4: In global mode, `timeout` pulses once per exposure and then stays low until the next `shutter_start`. A `shutter_start` during a running exposure restarts the count from zero.
- R5: `int_limit` and `gran_sel` are captured when the exposure or frame starts. Later changes have no effect on that run.
- R6: Rolling mode (`shutter_mode`=1). A `frame_start` sampled at edge E makes `rd_sync` high for the one cycle after E. At edge E, `rd_ptr` loads the value of `rd_ptr_init`, and it holds that value until the next such sync.
- R7: In rolling mode, `rst_sync` is high for one cycle after the edge that samples the N-th row-clock pulse since frame start, where N is the integration value. An N of 0 acts as 1. At that same edge, `rst_ptr` loads `rst_ptr_init`.
- R8: In rolling mode, `rst_sync` fires at most once per frame, even if row clocks continue. A new `frame_start` clears the row count. A row clock sampled together with `frame_start` is not counted.
- R9: In global mode, `frame_start` and `row_clk` are ignored (no `rd_sync`, no `rst_sync`). In rolling mode, `shutter_start` is ignored (no `timeout`).
- R10: A change of `shutter_mode` aborts a run in progress. No `timeout` or `rst_sync` results from it afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| shutter_mode | input | 1 | 0 = global shutter, 1 = rolling shutter |
| int_limit | input | 12 | Integration value (ticks or rows) |
| gran_sel | input | 2 | Tick period select: 1, 4, 16 or 256 clocks |
| shutter_start | input | 1 | Global exposure start strobe |
| frame_start | input | 1 | Rolling frame start strobe |
| row_clk | input | 1 | Row advance strobe, one cycle per row |
| rd_ptr_init | input | 10 | Start row for the read pointer |
| rst_ptr_init | input | 10 | Start row for the reset pointer |
| timeout | output | 1 | Global exposure end pulse |
| rd_sync | output | 1 | Read-pointer load sync pulse |
| rd_ptr | output | 10 | Last loaded read-pointer start value |
| rst_sync | output | 1 | Reset-pointer load sync pulse |
| rst_ptr | output | 10 | Last loaded reset-pointer start value |

## Verification
The hardest conditions to reach are strobes that coincide with state changes of the shared counter. Examples are a row clock in the same cycle as a frame start, a mode flip partway through an exposure, and a restart just before the count would have expired. Directed runs place each of these on exact cycles. Randomised runs vary the integration value, the granularity, the gaps between rows and noise on the strobes of the inactive mode. Long 256-clock tick runs are kept to short counts so that the largest divider is exercised without long waits.

// File: rtl/shtr_pkg.sv
// Shared types and helpers for the exposure integration timer.
package shtr_pkg;

    // Shutter mode as presented on the mode input.
    typedef enum logic {
        SHTR_GLOBAL  = 1'b0,
        SHTR_ROLLING = 1'b1
    } shtr_mode_e;

    // Tick period encoding for global mode.
    typedef enum logic [1:0] {
        GRAN_1   = 2'd0,
        GRAN_4   = 2'd1,
        GRAN_16  = 2'd2,
        GRAN_256 = 2'd3
    } gran_e;

    // Clocks per tick for a granularity code.
    function automatic int gran_period(input gran_e g);
        case (g)
            GRAN_1:  return 1;
            GRAN_4:  return 4;
            GRAN_16: return 16;
            default: return 256;
        endcase
    endfunction

endpackage

// File: rtl/shtr_tick_gen.sv
// Tick prescaler. Divides the clock by the selected granularity while run
// is high. The period is captured on clear, which also restarts the phase,
// so the first tick comes G cycles after the clear edge.
// Assumes PRE_W is wide enough to hold 255.
module shtr_tick_gen
    import shtr_pkg::*;
#(
    parameter int PRE_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       run,
    input  logic [1:0] gran_sel,
    output logic       tick
);

    logic [PRE_W-1:0] phase_q;
    logic [PRE_W-1:0] last_q;
    logic [PRE_W-1:0] last_d;

    // Terminal phase value for the requested period.
    always_comb last_d = PRE_W'(gran_period(gran_e'(gran_sel)) - 1);

    // A tick marks the final phase of each period.
    always_comb tick = run && !clear && (phase_q == last_q);

    // Phase counter and captured period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            last_q  <= '0;
        end else if (clear) begin
            phase_q <= '0;
            last_q  <= last_d;
        end else if (run) begin
            phase_q <= tick ? '0 : phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/shtr_int_counter.sv
// Shared integration counter. A start clears it, captures the target (raised
// to MIN_INT in global mode) and the run mode. Each step advances it.
// fire is a combinational strobe, raised on the step that makes the count
// reach the target; the run then ends. An abort ends the run silently.
// A start takes priority over both abort and step.
module shtr_int_counter
    import shtr_pkg::*;
#(
    parameter int CNT_W   = 12,
    parameter int MIN_INT = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  shtr_mode_e       mode_in,
    input  logic [CNT_W-1:0] limit_in,
    input  logic             step,
    output logic             active,
    output shtr_mode_e       run_mode,
    output logic             fire
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] tgt_q;
    logic [CNT_W-1:0] tgt_d;
    logic [CNT_W:0]   cnt_nxt;

    // Target for a new run: floor applies only to global mode.
    always_comb begin
        if (mode_in == SHTR_GLOBAL && limit_in < CNT_W'(MIN_INT))
            tgt_d = CNT_W'(MIN_INT);
        else
            tgt_d = limit_in;
    end

    // Reach detection on the incremented count.
    always_comb begin
        cnt_nxt = {1'b0, cnt_q} + 1'b1;
        fire    = active && step && !start && !abort
                  && (cnt_nxt >= {1'b0, tgt_q});
    end

    // Count, run flag and captured run parameters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            tgt_q    <= '0;
            active   <= 1'b0;
            run_mode <= SHTR_GLOBAL;
        end else if (start) begin
            cnt_q    <= '0;
            tgt_q    <= tgt_d;
            active   <= 1'b1;
            run_mode <= mode_in;
        end else if (abort) begin
            active   <= 1'b0;
        end else if (active && step) begin
            cnt_q    <= cnt_nxt[CNT_W-1:0];
            if (fire)
                active <= 1'b0;
        end
    end

endmodule

// File: rtl/shtr_sync_out.sv
// Output stage. Registers the one-cycle sync and timeout pulses and
// captures the pointer start values at the edge on which their sync is issued.
module shtr_sync_out
    import shtr_pkg::*;
#(
    parameter int PTR_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_load,
    input  logic [PTR_W-1:0] rd_init,
    input  logic             fire,
    input  shtr_mode_e       run_mode,
    input  logic [PTR_W-1:0] rst_init,
    output logic             timeout,
    output logic             rd_sync,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             rst_sync,
    output logic [PTR_W-1:0] rst_ptr
);

    logic rst_fire;

    // A rolling-mode reach becomes the reset-pointer sync.
    always_comb rst_fire = fire && (run_mode == SHTR_ROLLING);

    // Pulse outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timeout  <= 1'b0;
            rd_sync  <= 1'b0;
            rst_sync <= 1'b0;
        end else begin
            timeout  <= fire && (run_mode == SHTR_GLOBAL);
            rd_sync  <= rd_load;
            rst_sync <= rst_fire;
        end
    end

    // Pointer start values, loaded with their sync.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr  <= '0;
            rst_ptr <= '0;
        end else begin
            if (rd_load)
                rd_ptr <= rd_init;
            if (rst_fire)
                rst_ptr <= rst_init;
        end
    end

endmodule

// File: rtl/shtr_integ_timer.sv
// Exposure integration timer, top level. Routes the mode-specific strobes
// into one shared counter: global mode steps it with prescaled ticks, rolling
// mode steps it with row clocks. A change of mode aborts any run in progress.
// Assumes all strobes are one clock wide and synchronous to clk.
module shtr_integ_timer
    import shtr_pkg::*;
#(
    parameter int CNT_W   = 12,
    parameter int PTR_W   = 10,
    parameter int PRE_W   = 8,
    parameter int MIN_INT = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shutter_mode,
    input  logic [CNT_W-1:0] int_limit,
    input  logic [1:0]       gran_sel,
    input  logic             shutter_start,
    input  logic             frame_start,
    input  logic             row_clk,
    input  logic [PTR_W-1:0] rd_ptr_init,
    input  logic [PTR_W-1:0] rst_ptr_init,
    output logic             timeout,
    output logic             rd_sync,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             rst_sync,
    output logic [PTR_W-1:0] rst_ptr
);

    shtr_mode_e mode_now;
    shtr_mode_e mode_q;
    shtr_mode_e run_mode;
    logic       run_start;
    logic       run_abort;
    logic       active;
    logic       tick;
    logic       step;
    logic       fire;
    logic       rd_load;

    // Decode the mode and the strobes that belong to it.
    always_comb begin
        mode_now  = shtr_mode_e'(shutter_mode);
        run_start = (mode_now == SHTR_ROLLING) ? frame_start : shutter_start;
        run_abort = (mode_now != mode_q);
        rd_load   = (mode_now == SHTR_ROLLING) && frame_start;
        step      = (run_mode == SHTR_ROLLING) ? row_clk : tick;
    end

    // Previous mode, used to detect a mode change.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= SHTR_GLOBAL;
        else
            mode_q <= mode_now;
    end

    shtr_tick_gen #(
        .PRE_W    (PRE_W)
    ) i_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (run_start),
        .run      (active && (run_mode == SHTR_GLOBAL)),
        .gran_sel (gran_sel),
        .tick     (tick)
    );

    shtr_int_counter #(
        .CNT_W    (CNT_W),
        .MIN_INT  (MIN_INT)
    ) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (run_start),
        .abort    (run_abort),
        .mode_in  (mode_now),
        .limit_in (int_limit),
        .step     (step),
        .active   (active),
        .run_mode (run_mode),
        .fire     (fire)
    );

    shtr_sync_out #(
        .PTR_W    (PTR_W)
    ) i_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_load  (rd_load),
        .rd_init  (rd_ptr_init),
        .fire     (fire),
        .run_mode (run_mode),
        .rst_init (rst_ptr_init),
        .timeout  (timeout),
        .rd_sync  (rd_sync),
        .rd_ptr   (rd_ptr),
        .rst_sync (rst_sync),
        .rst_ptr  (rst_ptr)
    );

endmodule

// File: rtl/shtr_integ_timer_chk.sv
// Property checker for the exposure integration timer, bound to the top.
// It watches only the ports and keeps two small trackers of its own.
module shtr_integ_timer_chk #(
    parameter int PTR_W   = 10,
    parameter int MIN_INT = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             shutter_mode,
    input logic             shutter_start,
    input logic             timeout,
    input logic             rd_sync,
    input logic [PTR_W-1:0] rd_ptr,
    input logic             rst_sync,
    input logic [PTR_W-1:0] rst_ptr
);

    logic [15:0] since_start;
    logic        rst_done;

    // Clocks since the last global exposure start (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_start <= '0;
        else if (shutter_start && !shutter_mode)
            since_start <= '0;
        else if (since_start != 16'hFFFF)
            since_start <= since_start + 1'b1;
    end

    // Set once a reset-pointer sync has been seen in the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rst_done <= 1'b0;
        else if (rd_sync)
            rst_done <= 1'b0;
        else if (rst_sync)
            rst_done <= 1'b1;
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!timeout && !rd_sync && !rst_sync && rd_ptr == '0 && rst_ptr == '0));

    p_timeout_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !timeout);

    p_timeout_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (since_start >= 16'(MIN_INT)));

    p_rst_sync_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_sync |-> !rst_done);

    p_mode_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (!rd_sync && !rst_sync));

    p_rd_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_sync |-> $stable(rd_ptr));

    p_rst_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_sync |-> $stable(rst_ptr));

endmodule

bind shtr_integ_timer shtr_integ_timer_chk #(
    .PTR_W         (PTR_W),
    .MIN_INT       (MIN_INT)
) i_shtr_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .shutter_mode  (shutter_mode),
    .shutter_start (shutter_start),
    .timeout       (timeout),
    .rd_sync       (rd_sync),
    .rd_ptr        (rd_ptr),
    .rst_sync      (rst_sync),
    .rst_ptr       (rst_ptr)
);

// File: tb/test_shtr_integ_timer.sv
module test_shtr_integ_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode = 1'b0;
    logic [11:0] lim = '0;
    logic [1:0]  gsel = '0;
    logic        sstart = 1'b0;
    logic        fstart = 1'b0;
    logic        rclk = 1'b0;
    logic [9:0]  rdp = '0;
    logic [9:0]  rsp = '0;
    logic        timeout_w;
    logic        rd_sync_w;
    logic [9:0]  rd_ptr_w;
    logic        rst_sync_w;
    logic [9:0]  rst_ptr_w;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    shtr_integ_timer i_shtr_integ_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .shutter_mode  (mode),
        .int_limit     (lim),
        .gran_sel      (gsel),
        .shutter_start (sstart),
        .frame_start   (fstart),
        .row_clk       (rclk),
        .rd_ptr_init   (rdp),
        .rst_ptr_init  (rsp),
        .timeout       (timeout_w),
        .rd_sync       (rd_sync_w),
        .rd_ptr        (rd_ptr_w),
        .rst_sync      (rst_sync_w),
        .rst_ptr       (rst_ptr_w)
    );

    function automatic int gper(input int g);
        case (g)
            0: return 1;
            1: return 4;
            2: return 16;
            default: return 256;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Global exposure: rs = restart cycle, ab = mode-flip cycle, noise on rolling strobes.
    task automatic run_global(input int t, input int g, input int rs, input int ab, input bit noise);
        int texp;
        int expc;
        int first;
        int pulses;
        int other;
        int span;
        bit rnd;
        texp   = (t < 10) ? 10 : t;
        expc   = texp * gper(g);
        first  = -1;
        pulses = 0;
        other  = 0;
        rnd    = (rs == 0 && ab == 0);
        span   = (ab != 0) ? 100 : rs + expc + 30;
        @(negedge clk);
        mode = 1'b0; lim = 12'(t); gsel = 2'(g); sstart = 1'b1;
        @(negedge clk);
        sstart = 1'b0;
        if (rnd) begin
            lim  = 12'($urandom);
            gsel = 2'($urandom);
        end
        for (int k = 1; k <= span; k++) begin
            sstart = (rs != 0 && k == rs);
            if (ab != 0 && k == ab)      mode = 1'b1;
            if (ab != 0 && k == ab + 40) mode = 1'b0;
            if (noise) begin
                fstart = 1'($urandom);
                rclk   = 1'($urandom);
            end
            @(negedge clk);
            if (timeout_w) begin
                pulses++;
                if (first < 0) first = k;
            end
            if (rd_sync_w || rst_sync_w) other++;
        end
        sstart = 1'b0; fstart = 1'b0; rclk = 1'b0; mode = 1'b0;
        if (ab != 0) begin
            chk(pulses == 0, "R10 global abort", pulses, 0);
        end else begin
            chk(first == rs + expc, (rs != 0) ? "R4 restart" : "R2 timeout cycle", first, rs + expc);
            chk(pulses == 1, "R4 single pulse", pulses, 1);
            if (t < 10) chk(first == rs + expc, "R3 floor", first, rs + expc);
            if (rnd)    chk(first == expc, "R5 capture", first, expc);
        end
        if (noise) chk(other == 0, "R9 global ignores rolling strobes", other, 0);
    endtask

    // Rolling frame: same = row clock coincides with frame start.
    task automatic run_rolling(input int n, input bit same, input bit noise);
        int tgt;
        int rc;
        int bad;
        int fires;
        int tout;
        int rdx;
        int ptr_bad;
        logic [9:0] p;
        logic [9:0] q;
        tgt = (n == 0) ? 1 : n;
        rc = 0; bad = 0; fires = 0; tout = 0; rdx = 0; ptr_bad = 0;
        p = 10'($urandom);
        q = 10'($urandom);
        @(negedge clk);
        mode = 1'b1; lim = 12'(n); rdp = p; rsp = q; fstart = 1'b1; rclk = same;
        @(negedge clk);
        fstart = 1'b0; rclk = 1'b0; rdp = ~p; lim = 12'($urandom);
        chk(rd_sync_w == 1'b1, "R6 rd_sync", rd_sync_w, 1);
        chk(rd_ptr_w == p, "R6 rd_ptr load", rd_ptr_w, p);
        while (rc < tgt + 3) begin
            int gap;
            gap = $urandom % 3;
            for (int i = 0; i < gap; i++) begin
                rclk = 1'b0;
                if (noise) sstart = 1'($urandom);
                @(negedge clk);
                if (rst_sync_w) bad++;
                if (timeout_w)  tout++;
                if (rd_sync_w)  rdx++;
            end
            rclk = 1'b1;
            if (noise) sstart = 1'($urandom);
            rc++;
            @(negedge clk);
            rclk = 1'b0;
            if (rst_sync_w != (rc == tgt)) bad++;
            if (rst_sync_w) begin
                fires++;
                if (rst_ptr_w != q) ptr_bad++;
            end
            if (timeout_w) tout++;
            if (rd_sync_w) rdx++;
        end
        sstart = 1'b0;
        chk(bad == 0, "R7 rst_sync timing", bad, 0);
        chk(fires == 1, "R8 once per frame", fires, 1);
        chk(ptr_bad == 0, "R7 rst_ptr load", ptr_bad, 0);
        chk(rdx == 0 && rd_ptr_w == p, "R6 rd_ptr hold", rd_ptr_w, p);
        if (noise) chk(tout == 0, "R9 rolling ignores shutter_start", tout, 0);
    endtask

    // Frame start followed by m rows, fewer than n: no reset sync expected.
    task automatic partial_frame(input int n, input int m);
        int seen;
        seen = 0;
        @(negedge clk);
        mode = 1'b1; lim = 12'(n); fstart = 1'b1;
        @(negedge clk);
        fstart = 1'b0;
        for (int i = 0; i < m; i++) begin
            rclk = 1'b1;
            @(negedge clk);
            rclk = 1'b0;
            if (rst_sync_w) seen++;
        end
        chk(seen == 0, "R8 partial frame", seen, 0);
    endtask

    // Rolling run interrupted by a brief switch to global mode.
    task automatic roll_abort();
        int seen;
        seen = 0;
        partial_frame(6, 2);
        mode = 1'b0;
        repeat (3) @(negedge clk);
        mode = 1'b1;
        for (int i = 0; i < 10; i++) begin
            rclk = 1'b1;
            @(negedge clk);
            rclk = 1'b0;
            if (rst_sync_w) seen++;
            @(negedge clk);
            if (rst_sync_w) seen++;
        end
        chk(seen == 0, "R10 rolling abort", seen, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!timeout_w && !rd_sync_w && !rst_sync_w, "R1 pulses in reset", timeout_w, 0);
        chk(rd_ptr_w == 0 && rst_ptr_w == 0, "R1 pointers in reset", rd_ptr_w, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!timeout_w && !rd_sync_w && !rst_sync_w, "R1 after reset", rst_sync_w, 0);

        // Directed global corners.
        run_global(10, 0, 0, 0, 0);
        run_global(3, 0, 0, 0, 0);      // R3
        run_global(0, 1, 0, 0, 0);      // R3
        run_global(12, 3, 0, 0, 0);     // R2, largest tick
        run_global(4095, 0, 0, 0, 0);   // R2, largest count
        run_global(20, 0, 12, 0, 0);    // R4 restart mid-run
        run_global(30, 0, 0, 5, 0);     // R10
        run_global(15, 2, 0, 0, 1);     // R9

        // Directed rolling corners.
        run_rolling(1, 0, 0);
        run_rolling(0, 0, 0);           // R7 zero acts as one
        run_rolling(2, 1, 0);           // R8 coinciding row clock
        partial_frame(5, 3);
        run_rolling(5, 0, 0);           // R8 count cleared by new frame
        roll_abort();
        run_rolling(4095, 0, 0);

        // Randomised mix.
        for (int i = 0; i < 10; i++) begin
            int g;
            int t;
            g = $urandom % 4;
            t = (g == 3) ? ($urandom % 21) : ($urandom % 201);
            run_global(t, g, 0, 0, 1'($urandom));
        end
        for (int i = 0; i < 15; i++) begin
            run_rolling($urandom % 61, 1'($urandom), 1'($urandom));
        end

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", 200000);
            $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule